// File: doc/BRIEF.md
# Control-Flow Resolver

A purely combinational unit that settles, for one instruction, where the program counter goes next in a 32-bit RISC pipeline. It takes the current PC, the two register operand values, an already sign-extended branch offset, a 26-bit absolute jump field, a destination register index and a 4-bit operation code. It returns whether the flow is redirected, the next PC, a request to write a return address (value and register index), and a trap request.

Conditional branches compare the two operands for equality or test the first operand as a signed number against zero. Absolute jumps take their target from the instruction field inside the current 256 MB region. Register jumps take their target from the first operand. The linking forms save the address of the following instruction. The conditional traps only raise a request and leave the flow sequential. Fetch, delay slots and exception vectoring are handled elsewhere.

Top module: `cf_resolver`

## Requirements
- R1: With op code 0 (none) or any unassigned code (14, 15), taken is 0, next PC is PC+4, no link write and no trap, whatever the operand values.
- R2: Op 1 is taken when the operands are equal. Op 2 is taken when they differ.
- R3: Ops 3, 4, 5 and 6 test the first operand as a signed number against zero, for greater-than, less-than, greater-or-equal and less-or-equal respectively, and are taken when the test holds.
- R4: A taken branch yields PC+4 plus the offset shifted left by two, wrapping modulo 2^32. A branch that is not taken yields PC+4.
- R5: Op 7 (jump) is always taken, and its next PC is bits 31:28 of PC+4, then the 26-bit target, then two zero bits.
- R6: Op 9 (register jump) is always taken, and its next PC is the first operand.
- R7: Op 8 (jump and link) forms its target as in R5 and writes PC+4 into register 31.
- R8: Op 10 jumps to the first operand and writes PC+4 into the register named by the destination index input. Op 11 jumps to the first operand and writes PC+4 into register 31, and it ignores the destination index.
- R9: Op 12 raises a trap when the operands are equal. Op 13 raises a trap when the first operand is signed greater than or equal to the second. A trap op never redirects: taken is 0 and next PC is PC+4.
- R10: The link write enable is 1 only for ops 8, 10 and 11, and when it is 0 the link index and link value outputs are 0. Trap and taken are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_i | input | 32 | Address of the current instruction |
| rs_val_i | input | 32 | First register operand |
| rt_val_i | input | 32 | Second register operand |
| offset_i | input | 32 | Sign-extended branch offset, in words |
| jtarget_i | input | 26 | Absolute jump field, in words |
| rd_idx_i | input | 5 | Explicit link destination index |
| op_i | input | 4 | Operation code |
| taken_o | output | 1 | Flow is redirected |
| next_pc_o | output | 32 | Address of the next instruction |
| link_we_o | output | 1 | Return-address write request |
| link_idx_o | output | 5 | Register that receives the return address |
| link_data_o | output | 32 | Return address value |
| trap_o | output | 1 | Trap request |

## Verification
The hardest cases to reach are those where carries cross a boundary. One is a PC near the end of a 256 MB region, so that adding four changes bits 31:28 before the jump field is inserted. Another is a PC near the top of the address space, where a positive branch offset wraps to a low address. Directed tasks drive such PC values on purpose, for example 0x0FFFFFFC for a jump and 0xFFFFFFF8 for a branch. They also place operands on the signed boundaries 0, 0x7FFFFFFF and 0x80000000. Comparing as unsigned or testing the wrong inequality flips the result at those values.

// File: rtl/cfr_pkg.sv
package cfr_pkg;
  typedef enum logic [3:0] {
    OP_NONE  = 4'd0,
    OP_BEQ   = 4'd1,
    OP_BNE   = 4'd2,
    OP_BGTZ  = 4'd3,
    OP_BLTZ  = 4'd4,
    OP_BGEZ  = 4'd5,
    OP_BLEZ  = 4'd6,
    OP_J     = 4'd7,
    OP_JAL   = 4'd8,
    OP_JR    = 4'd9,
    OP_JALR  = 4'd10,
    OP_JALRA = 4'd11,
    OP_TEQ   = 4'd12,
    OP_TGE   = 4'd13
  } cf_op_e;

  typedef enum logic [1:0] {
    TGT_SEQ = 2'd0,
    TGT_BR  = 2'd1,
    TGT_ABS = 2'd2,
    TGT_REG = 2'd3
  } tgt_sel_e;
endpackage

// File: rtl/cfr_cond.sv
module cfr_cond
  import cfr_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  cf_op_e          op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic            br_hit,
  output logic            trap_hit,
  output tgt_sel_e        tgt_sel
);
  logic eq, neg, zero, sge;

  assign eq   = (a == b);
  assign neg  = a[XLEN-1];
  assign zero = (a == '0);
  assign sge  = ($signed(a) >= $signed(b));

  always_comb begin
    br_hit   = 1'b0;
    trap_hit = 1'b0;
    tgt_sel  = TGT_SEQ;
    case (op)
      OP_BEQ:  br_hit = eq;
      OP_BNE:  br_hit = !eq;
      OP_BGTZ: br_hit = !neg && !zero;
      OP_BLTZ: br_hit = neg;
      OP_BGEZ: br_hit = !neg;
      OP_BLEZ: br_hit = neg || zero;
      OP_J, OP_JAL: br_hit = 1'b1;
      OP_JR, OP_JALR, OP_JALRA: br_hit = 1'b1;
      OP_TEQ:  trap_hit = eq;
      OP_TGE:  trap_hit = sge;
      default: ;
    endcase
    case (op)
      OP_BEQ, OP_BNE, OP_BGTZ, OP_BLTZ, OP_BGEZ, OP_BLEZ: tgt_sel = TGT_BR;
      OP_J, OP_JAL:             tgt_sel = TGT_ABS;
      OP_JR, OP_JALR, OP_JALRA: tgt_sel = TGT_REG;
      default:                  tgt_sel = TGT_SEQ;
    endcase
  end
endmodule

// File: rtl/cfr_target.sv
module cfr_target #(
  parameter int XLEN  = 32,
  parameter int TGT_W = 26
) (
  input  logic [XLEN-1:0]  pc,
  input  logic [XLEN-1:0]  offset,
  input  logic [TGT_W-1:0] jtgt,
  output logic [XLEN-1:0]  seq_pc,
  output logic [XLEN-1:0]  br_pc,
  output logic [XLEN-1:0]  abs_pc
);
  localparam int REGION_W = XLEN - TGT_W - 2;

  function automatic logic [XLEN-1:0] step(input logic [XLEN-1:0] p);
    return p + XLEN'(4);
  endfunction

  function automatic logic [XLEN-1:0] rel(input logic [XLEN-1:0] base,
                                          input logic [XLEN-1:0] off);
    return base + {off[XLEN-3:0], 2'b00};
  endfunction

  function automatic logic [XLEN-1:0] region(input logic [XLEN-1:0] base,
                                             input logic [TGT_W-1:0] t);
    return {base[XLEN-1 -: REGION_W], t, 2'b00};
  endfunction

  assign seq_pc = step(pc);
  assign br_pc  = rel(seq_pc, offset);
  assign abs_pc = region(seq_pc, jtgt);
endmodule

// File: rtl/cfr_link.sv
module cfr_link
  import cfr_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int IDX_W     = 5,
  parameter int LINK_REG  = 31
) (
  input  cf_op_e           op,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [XLEN-1:0]  ret_addr,
  output logic             we,
  output logic [IDX_W-1:0] idx,
  output logic [XLEN-1:0]  data
);
  localparam logic [IDX_W-1:0] RA_IDX = IDX_W'(LINK_REG);

  always_comb begin
    we   = 1'b0;
    idx  = '0;
    data = '0;
    case (op)
      OP_JAL, OP_JALRA: begin
        we   = 1'b1;
        idx  = RA_IDX;
        data = ret_addr;
      end
      OP_JALR: begin
        we   = 1'b1;
        idx  = rd_idx;
        data = ret_addr;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/cf_resolver.sv
module cf_resolver
  import cfr_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int TGT_W    = 26,
  parameter int IDX_W    = 5,
  parameter int LINK_REG = 31
) (
  input  logic [XLEN-1:0]  pc_i,
  input  logic [XLEN-1:0]  rs_val_i,
  input  logic [XLEN-1:0]  rt_val_i,
  input  logic [XLEN-1:0]  offset_i,
  input  logic [TGT_W-1:0] jtarget_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  input  logic [3:0]       op_i,
  output logic             taken_o,
  output logic [XLEN-1:0]  next_pc_o,
  output logic             link_we_o,
  output logic [IDX_W-1:0] link_idx_o,
  output logic [XLEN-1:0]  link_data_o,
  output logic             trap_o
);
  cf_op_e          op;
  tgt_sel_e        tgt_sel;
  logic            cond_hit;
  logic            trap_hit;
  logic [XLEN-1:0] seq_pc;
  logic [XLEN-1:0] br_pc;
  logic [XLEN-1:0] abs_pc;

  assign op = cf_op_e'(op_i);

  cfr_cond #(.XLEN(XLEN)) u_cond (
    .op       (op),
    .a        (rs_val_i),
    .b        (rt_val_i),
    .br_hit   (cond_hit),
    .trap_hit (trap_hit),
    .tgt_sel  (tgt_sel)
  );

  cfr_target #(.XLEN(XLEN), .TGT_W(TGT_W)) u_target (
    .pc     (pc_i),
    .offset (offset_i),
    .jtgt   (jtarget_i),
    .seq_pc (seq_pc),
    .br_pc  (br_pc),
    .abs_pc (abs_pc)
  );

  cfr_link #(.XLEN(XLEN), .IDX_W(IDX_W), .LINK_REG(LINK_REG)) u_link (
    .op       (op),
    .rd_idx   (rd_idx_i),
    .ret_addr (seq_pc),
    .we       (link_we_o),
    .idx      (link_idx_o),
    .data     (link_data_o)
  );

  always_comb begin
    next_pc_o = seq_pc;
    if (cond_hit) begin
      case (tgt_sel)
        TGT_BR:  next_pc_o = br_pc;
        TGT_ABS: next_pc_o = abs_pc;
        TGT_REG: next_pc_o = rs_val_i;
        default: next_pc_o = seq_pc;
      endcase
    end
  end

  assign taken_o = cond_hit;
  assign trap_o  = trap_hit;
endmodule

// File: rtl/cf_resolver_chk.sv
module cf_resolver_chk #(
  parameter int XLEN  = 32,
  parameter int IDX_W = 5
) (
  input logic [XLEN-1:0]  pc_i,
  input logic [XLEN-1:0]  rs_val_i,
  input logic [XLEN-1:0]  rt_val_i,
  input logic [3:0]       op_i,
  input logic             taken_o,
  input logic [XLEN-1:0]  next_pc_o,
  input logic             link_we_o,
  input logic [IDX_W-1:0] link_idx_o,
  input logic [XLEN-1:0]  link_data_o,
  input logic             trap_o,
  input logic [XLEN-1:0]  seq_pc
);
  logic known;
  assign known = !$isunknown({pc_i, rs_val_i, rt_val_i, op_i});

  always_comb begin
    if (known) begin
      // R1, R4: without redirection the flow stays sequential
      a_r4_seq_when_idle: assert (taken_o || next_pc_o == pc_i + 32'd4)
        else $error("sequential next PC wrong");
      // R10: trap and redirect are exclusive
      a_r10_trap_excl: assert (!(trap_o && taken_o))
        else $error("trap with redirect");
      // R7, R8: link value is the following address
      a_r8_link_value: assert (!link_we_o || link_data_o == seq_pc)
        else $error("link value wrong");
      // R10: idle link outputs are zero
      a_r10_link_idle: assert (link_we_o || (link_idx_o == '0 && link_data_o == '0))
        else $error("link outputs not cleared");
      // R1: unassigned codes do nothing
      a_r1_unused_quiet: assert (op_i < 4'd14 || !(taken_o || trap_o || link_we_o))
        else $error("unused op acted");
      // R3: greater-than-zero test is signed
      a_r3_bgtz_signed: assert (op_i != 4'd3 || taken_o == ($signed(rs_val_i) > 0))
        else $error("signed zero compare wrong");
      // R9: trap on equal
      a_r9_teq: assert (op_i != 4'd12 || trap_o == (rs_val_i == rt_val_i))
        else $error("equal trap wrong");
    end
  end
endmodule

bind cf_resolver cf_resolver_chk #(.XLEN(XLEN), .IDX_W(IDX_W)) u_chk (
  .pc_i        (pc_i),
  .rs_val_i    (rs_val_i),
  .rt_val_i    (rt_val_i),
  .op_i        (op_i),
  .taken_o     (taken_o),
  .next_pc_o   (next_pc_o),
  .link_we_o   (link_we_o),
  .link_idx_o  (link_idx_o),
  .link_data_o (link_data_o),
  .trap_o      (trap_o),
  .seq_pc      (seq_pc)
);

// File: tb/cf_resolver_bench.sv
module cf_resolver_bench;
  logic        clk = 1'b0;
  logic [31:0] pc, rs, rt, off;
  logic [25:0] jt;
  logic [4:0]  rd;
  logic [3:0]  op;
  logic        taken, we, trap;
  logic [31:0] npc, ldata;
  logic [4:0]  lidx;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cf_resolver u_cf_resolver (
    .pc_i(pc), .rs_val_i(rs), .rt_val_i(rt), .offset_i(off),
    .jtarget_i(jt), .rd_idx_i(rd), .op_i(op),
    .taken_o(taken), .next_pc_o(npc), .link_we_o(we),
    .link_idx_o(lidx), .link_data_o(ldata), .trap_o(trap)
  );

  task automatic drive(input logic [3:0] o, input logic [31:0] p,
                       input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] of, input logic [25:0] t,
                       input logic [4:0] r);
    @(posedge clk);
    op = o; pc = p; rs = a; rt = b; off = of; jt = t; rd = r;
    @(negedge clk);
  endtask

  task automatic expect_out(input string tag, input logic e_tk,
                            input logic [31:0] e_pc, input logic e_we,
                            input logic [4:0] e_idx, input logic [31:0] e_d,
                            input logic e_tr);
    logic [71:0] act, exp;
    act = {taken, npc, we, lidx, ldata, trap} & {{1{1'b1}}, 32'hFFFFFFFF, 1'b1, 5'h1F, 32'hFFFFFFFF, 1'b1};
    exp = {e_tk, e_pc, e_we, e_idx, e_d, e_tr};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: tk=%b pc=%h we=%b idx=%0d d=%h tr=%b expected tk=%b pc=%h we=%b idx=%0d d=%h tr=%b",
               tag, taken, npc, we, lidx, ldata, trap, e_tk, e_pc, e_we, e_idx, e_d, e_tr);
    end
  endtask

  task automatic t_idle;
    drive(4'd0, 32'h100, 32'h5, 32'h5, 32'h10, 26'h3, 5'd4);
    expect_out("R1 none op", 0, 32'h104, 0, 0, 0, 0);
    drive(4'd15, 32'h200, 32'h7, 32'h7, 32'h1, 26'h1, 5'd9);
    expect_out("R1 unused 15", 0, 32'h204, 0, 0, 0, 0);
    drive(4'd14, 32'h300, 32'h0, 32'h0, 32'h1, 26'h1, 5'd9);
    expect_out("R1 unused 14", 0, 32'h304, 0, 0, 0, 0);
  endtask

  task automatic t_equality;
    drive(4'd1, 32'h1000, 32'hAB, 32'hAB, 32'd3, 26'h0, 5'd0);
    expect_out("R2 R4 beq taken", 1, 32'h1010, 0, 0, 0, 0);
    drive(4'd1, 32'h1000, 32'hAB, 32'hAC, 32'd3, 26'h0, 5'd0);
    expect_out("R2 R4 beq not taken", 0, 32'h1004, 0, 0, 0, 0);
    drive(4'd2, 32'h1000, 32'h1, 32'h2, 32'hFFFFFFFE, 26'h0, 5'd0);
    expect_out("R2 R4 bne backward", 1, 32'h0FFC, 0, 0, 0, 0);
    drive(4'd2, 32'h1000, 32'h9, 32'h9, 32'h5, 26'h0, 5'd0);
    expect_out("R2 bne equal", 0, 32'h1004, 0, 0, 0, 0);
  endtask

  task automatic t_zero_compare;
    drive(4'd3, 32'h40, 32'h0, 32'h0, 32'd1, 26'h0, 5'd0);
    expect_out("R3 bgtz zero", 0, 32'h44, 0, 0, 0, 0);
    drive(4'd3, 32'h40, 32'h1, 32'h0, 32'd1, 26'h0, 5'd0);
    expect_out("R3 bgtz one", 1, 32'h48, 0, 0, 0, 0);
    drive(4'd3, 32'h40, 32'h80000000, 32'h0, 32'd1, 26'h0, 5'd0);
    expect_out("R3 bgtz most negative", 0, 32'h44, 0, 0, 0, 0);
    drive(4'd4, 32'h40, 32'h80000000, 32'h0, 32'd2, 26'h0, 5'd0);
    expect_out("R3 bltz negative", 1, 32'h4C, 0, 0, 0, 0);
    drive(4'd4, 32'h40, 32'h0, 32'h0, 32'd2, 26'h0, 5'd0);
    expect_out("R3 bltz zero", 0, 32'h44, 0, 0, 0, 0);
    drive(4'd5, 32'h40, 32'h0, 32'h0, 32'd2, 26'h0, 5'd0);
    expect_out("R3 bgez zero", 1, 32'h4C, 0, 0, 0, 0);
    drive(4'd5, 32'h40, 32'hFFFFFFFF, 32'h0, 32'd2, 26'h0, 5'd0);
    expect_out("R3 bgez minus one", 0, 32'h44, 0, 0, 0, 0);
    drive(4'd6, 32'h40, 32'h0, 32'h0, 32'd2, 26'h0, 5'd0);
    expect_out("R3 blez zero", 1, 32'h4C, 0, 0, 0, 0);
    drive(4'd6, 32'h40, 32'h7FFFFFFF, 32'h0, 32'd2, 26'h0, 5'd0);
    expect_out("R3 blez max positive", 0, 32'h44, 0, 0, 0, 0);
  endtask

  task automatic t_wrap;
    drive(4'd1, 32'hFFFFFFF8, 32'h3, 32'h3, 32'd4, 26'h0, 5'd0);
    expect_out("R4 offset wraps", 1, 32'h0000000C, 0, 0, 0, 0);
  endtask

  task automatic t_jumps;
    drive(4'd7, 32'h0FFFFFFC, 32'h0, 32'h0, 32'h0, 26'h0000010, 5'd3);
    expect_out("R5 jump region carry", 1, 32'h10000040, 0, 0, 0, 0);
    drive(4'd8, 32'h400, 32'h0, 32'h0, 32'h0, 26'h3FFFFFF, 5'd3);
    expect_out("R7 jal", 1, 32'h0FFFFFFC, 1, 5'd31, 32'h404, 0);
    drive(4'd9, 32'h800, 32'h12345678, 32'h0, 32'h0, 26'h0, 5'd3);
    expect_out("R6 jr", 1, 32'h12345678, 0, 0, 0, 0);
    drive(4'd10, 32'h800, 32'h00002000, 32'h0, 32'h0, 26'h0, 5'd5);
    expect_out("R8 jalr explicit", 1, 32'h00002000, 1, 5'd5, 32'h804, 0);
    drive(4'd11, 32'h900, 32'h00003000, 32'h0, 32'h0, 26'h0, 5'd5);
    expect_out("R8 jalr to ra", 1, 32'h00003000, 1, 5'd31, 32'h904, 0);
  endtask

  task automatic t_traps;
    drive(4'd12, 32'hA00, 32'h77, 32'h77, 32'd8, 26'h5, 5'd2);
    expect_out("R9 teq equal", 0, 32'hA04, 0, 0, 0, 1);
    drive(4'd12, 32'hA00, 32'h77, 32'h78, 32'd8, 26'h5, 5'd2);
    expect_out("R9 teq differ", 0, 32'hA04, 0, 0, 0, 0);
    drive(4'd13, 32'hA00, 32'hFFFFFFFF, 32'h1, 32'd8, 26'h5, 5'd2);
    expect_out("R9 tge signed less", 0, 32'hA04, 0, 0, 0, 0);
    drive(4'd13, 32'hA00, 32'h5, 32'h5, 32'd8, 26'h5, 5'd2);
    expect_out("R9 tge equal", 0, 32'hA04, 0, 0, 0, 1);
    drive(4'd13, 32'hA00, 32'h1, 32'hFFFFFFFF, 32'd8, 26'h5, 5'd2);
    expect_out("R9 R10 tge over negative", 0, 32'hA04, 0, 0, 0, 1);
  endtask

  initial begin
    op = 0; pc = 0; rs = 0; rt = 0; off = 0; jt = 0; rd = 0;
    t_idle();
    t_equality();
    t_zero_compare();
    t_wrap();
    t_jumps();
    t_traps();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule